// File: doc/BRIEF.md
# Prioritized CAN Interrupt Identifier

This block collects every interrupt source of a CAN controller onto one request line and reports which source needs service as a small numeric code. One source is the combined status/error source: it is raised by a successful transmit, a successful receive, a new last-error code, or a change of the error-warning or bus-off flag. A second source is a special receive-only object. The remaining sources are fourteen ordinary message objects, each of which can flag a completed transmit or receive.

Each source keeps a registered pending bit. The reported code is the lowest-numbered pending source, and a lower code means higher priority. Software services the sources in a loop. It reads the status byte, which clears the status/error source. It then clears an object's pending bit with a strobe and reads the code again until the code is zero. The transmit-OK and receive-OK flags are held separately, and software clears them with their own strobes.

Top module: `can_irq_id`

## Requirements
- R1: After reset the code is 0, the request line is low, and every pending bit and both OK flags are clear.
- R2: Code map. 0 means nothing is pending, 1 is the status/error source, 2 is the special object, and 3 to 16 are message objects 1 to 14 (code = object + 2). Port bit k of each object vector belongs to object k+1.
- R3: When several sources are pending, the code names the one with the lowest code.
- R4: The request line is high exactly when the global enable is set and the code is non-zero. The global enable does not stop pending bits from being set, and it does not change the code.
- R5: A transmit-OK, receive-OK or last-error event sets the status/error pending bit only while the status enable is set. With that enable clear, these events are ignored by the pending bit.
- R6: A change pulse on the error-warning or bus-off flag sets the status/error pending bit only while the error enable is set.
- R7: An object's pending bit is set by its transmit-done pulse only while its transmit enable is set, and by its receive-done pulse only while its receive enable is set.
- R8: An object's pending bit stays set until its own clear strobe. A status read does not clear it, so after the status/error source is cleared, that object's code becomes the reported code.
- R9: A status read clears the status/error pending bit. The transmit-OK and receive-OK flags are set by their events whatever the enables are, and each stays set until its own clear strobe.
- R10: If a set condition and a clear strobe for the same pending bit or flag arrive in the same cycle, the bit ends up set.
- R11: The special object's pending bit is set by its receive-done pulse while its receive enable is set, and it is cleared by its own clear strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_en | input | 1 | Global interrupt enable |
| stat_en | input | 1 | Status interrupt enable |
| err_en | input | 1 | Error interrupt enable |
| tx_ok_evt | input | 1 | Pulse: a message was sent successfully |
| rx_ok_evt | input | 1 | Pulse: a message was received successfully |
| lec_evt | input | 1 | Pulse: a new last-error code was written |
| ewarn_chg | input | 1 | Pulse: the error-warning flag changed |
| boff_chg | input | 1 | Pulse: the bus-off flag changed |
| status_rd | input | 1 | Strobe: software read of the status byte |
| txok_clr | input | 1 | Strobe: clear the transmit-OK flag |
| rxok_clr | input | 1 | Strobe: clear the receive-OK flag |
| obj_tx_done | input | NUM_OBJ | Per-object transmit-complete pulses |
| obj_rx_done | input | NUM_OBJ | Per-object receive-complete pulses |
| obj_tx_en | input | NUM_OBJ | Per-object transmit interrupt enables |
| obj_rx_en | input | NUM_OBJ | Per-object receive interrupt enables |
| obj_clr | input | NUM_OBJ | Per-object pending clear strobes |
| spec_rx_done | input | 1 | Special object receive-complete pulse |
| spec_rx_en | input | 1 | Special object receive interrupt enable |
| spec_clr | input | 1 | Special object pending clear strobe |
| irq_code | output | $clog2(NUM_OBJ+3) | Highest-priority pending source code |
| irq_req | output | 1 | Interrupt request line |
| stat_pend | output | 1 | Status/error source pending |
| spec_pend | output | 1 | Special object pending |
| obj_pend | output | NUM_OBJ | Per-object pending bits |
| tx_ok_flag | output | 1 | Transmit-OK flag |
| rx_ok_flag | output | 1 | Receive-OK flag |

## Verification
On every cycle, the assertions check the following:
- the request line agrees with the global enable and the code;
- a pending status/error source forces code 1;
- the special object outranks every ordinary object;
- no code falls outside the map;
- an enabled completion pulse is set in the next cycle even when a clear strobe arrives with it;
- object pending bits survive until their own clear;
- a status read with no new status/error event leaves that source clear.

The bench scenarios show the service sequences. In one, a single transfer raises code 1 and an object code at the same time, and the object code appears once the status read is done. Others show that disabled directions and disabled sources are ignored, and that the OK flags outlive a status read.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
  // Source slot indices in the internal pending vector; the order is the priority.
  localparam int unsigned SLOT_STAT = 0;
  localparam int unsigned SLOT_SPEC = 1;
  localparam int unsigned SLOT_OBJ0 = 2;
  // Number of slots ahead of the ordinary objects.
  localparam int unsigned FIXED_SLOTS = 2;
endpackage

// File: rtl/can_irq_pend_bit.sv
module can_irq_pend_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_d;
  logic q_en;

  // The set input outranks the clear strobe.
  always_comb begin
    q_en = set_i | clr_i;
    q_d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_o <= 1'b0;
    end else if (q_en) begin
      q_o <= q_d;
    end
  end
endmodule

// File: rtl/can_irq_prio.sv
module can_irq_prio #(
  parameter int unsigned NUM_SRC = 16,
  parameter int unsigned CODE_W  = 5
) (
  input  logic [NUM_SRC-1:0] req_i,
  output logic [CODE_W-1:0]  code_o
);
  // Slot i reports code i+1; scanning downward leaves the lowest slot in place.
  always_comb begin
    code_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        code_o = CODE_W'(i + 1);
      end
    end
  end
endmodule

// File: rtl/can_irq_id.sv
module can_irq_id #(
  parameter int unsigned NUM_OBJ = 14,
  localparam int unsigned CODE_W = $clog2(NUM_OBJ + 3)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               glb_en,
  input  logic               stat_en,
  input  logic               err_en,
  input  logic               tx_ok_evt,
  input  logic               rx_ok_evt,
  input  logic               lec_evt,
  input  logic               ewarn_chg,
  input  logic               boff_chg,
  input  logic               status_rd,
  input  logic               txok_clr,
  input  logic               rxok_clr,
  input  logic [NUM_OBJ-1:0] obj_tx_done,
  input  logic [NUM_OBJ-1:0] obj_rx_done,
  input  logic [NUM_OBJ-1:0] obj_tx_en,
  input  logic [NUM_OBJ-1:0] obj_rx_en,
  input  logic [NUM_OBJ-1:0] obj_clr,
  input  logic               spec_rx_done,
  input  logic               spec_rx_en,
  input  logic               spec_clr,
  output logic [CODE_W-1:0]  irq_code,
  output logic               irq_req,
  output logic               stat_pend,
  output logic               spec_pend,
  output logic [NUM_OBJ-1:0] obj_pend,
  output logic               tx_ok_flag,
  output logic               rx_ok_flag
);
  import can_irq_pkg::*;

  localparam int unsigned NUM_SRC = NUM_OBJ + FIXED_SLOTS;

  logic [NUM_SRC-1:0] src_set;
  logic [NUM_SRC-1:0] src_clr;
  logic [NUM_SRC-1:0] src_pend;

  always_comb begin
    src_set[SLOT_STAT] = (stat_en & (tx_ok_evt | rx_ok_evt | lec_evt))
                       | (err_en & (ewarn_chg | boff_chg));
    src_clr[SLOT_STAT] = status_rd;
    src_set[SLOT_SPEC] = spec_rx_en & spec_rx_done;
    src_clr[SLOT_SPEC] = spec_clr;
  end

  for (genvar k = 0; k < NUM_OBJ; k++) begin : g_obj_src
    always_comb begin
      src_set[SLOT_OBJ0 + k] = (obj_tx_en[k] & obj_tx_done[k])
                             | (obj_rx_en[k] & obj_rx_done[k]);
      src_clr[SLOT_OBJ0 + k] = obj_clr[k];
    end
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_pend
    can_irq_pend_bit u_pend (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (src_set[s]),
      .clr_i (src_clr[s]),
      .q_o   (src_pend[s])
    );
  end

  can_irq_pend_bit u_txok (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (tx_ok_evt),
    .clr_i (txok_clr),
    .q_o   (tx_ok_flag)
  );

  can_irq_pend_bit u_rxok (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (rx_ok_evt),
    .clr_i (rxok_clr),
    .q_o   (rx_ok_flag)
  );

  can_irq_prio #(
    .NUM_SRC (NUM_SRC),
    .CODE_W  (CODE_W)
  ) u_prio (
    .req_i  (src_pend),
    .code_o (irq_code)
  );

  always_comb begin
    stat_pend = src_pend[SLOT_STAT];
    spec_pend = src_pend[SLOT_SPEC];
    obj_pend  = src_pend[NUM_SRC-1:SLOT_OBJ0];
    irq_req   = glb_en & (irq_code != '0);
  end
endmodule

// File: rtl/can_irq_id_chk.sv
module can_irq_id_chk #(
  parameter int unsigned NUM_OBJ = 14,
  parameter int unsigned CODE_W  = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               glb_en,
  input logic               stat_en,
  input logic               err_en,
  input logic               tx_ok_evt,
  input logic               rx_ok_evt,
  input logic               lec_evt,
  input logic               ewarn_chg,
  input logic               boff_chg,
  input logic               status_rd,
  input logic [NUM_OBJ-1:0] obj_tx_done,
  input logic [NUM_OBJ-1:0] obj_rx_done,
  input logic [NUM_OBJ-1:0] obj_tx_en,
  input logic [NUM_OBJ-1:0] obj_rx_en,
  input logic [NUM_OBJ-1:0] obj_clr,
  input logic [CODE_W-1:0]  irq_code,
  input logic               irq_req,
  input logic               stat_pend,
  input logic               spec_pend,
  input logic [NUM_OBJ-1:0] obj_pend
);
  logic [NUM_OBJ-1:0] hit;
  logic [NUM_OBJ-1:0] keep;
  logic               stat_hit;

  always_comb begin
    hit      = (obj_tx_done & obj_tx_en) | (obj_rx_done & obj_rx_en);
    keep     = obj_pend & ~obj_clr;
    stat_hit = (stat_en & (tx_ok_evt | rx_ok_evt | lec_evt)) | (err_en & (ewarn_chg | boff_chg));
  end

  p_req_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |-> !irq_req);
  p_req_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_en && irq_code != '0) |-> irq_req);
  p_code_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_code <= CODE_W'(NUM_OBJ + 2));
  p_stat_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stat_pend |-> irq_code == CODE_W'(1));
  p_spec_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_pend && spec_pend) |-> irq_code == CODE_W'(2));
  p_obj_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> ((obj_pend & $past(hit)) == $past(hit)));
  p_obj_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (keep != '0) |=> ((obj_pend & $past(keep)) == $past(keep)));
  p_stat_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !stat_hit) |=> !stat_pend);
endmodule

bind can_irq_id can_irq_id_chk #(
  .NUM_OBJ (NUM_OBJ),
  .CODE_W  (CODE_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .glb_en      (glb_en),
  .stat_en     (stat_en),
  .err_en      (err_en),
  .tx_ok_evt   (tx_ok_evt),
  .rx_ok_evt   (rx_ok_evt),
  .lec_evt     (lec_evt),
  .ewarn_chg   (ewarn_chg),
  .boff_chg    (boff_chg),
  .status_rd   (status_rd),
  .obj_tx_done (obj_tx_done),
  .obj_rx_done (obj_rx_done),
  .obj_tx_en   (obj_tx_en),
  .obj_rx_en   (obj_rx_en),
  .obj_clr     (obj_clr),
  .irq_code    (irq_code),
  .irq_req     (irq_req),
  .stat_pend   (stat_pend),
  .spec_pend   (spec_pend),
  .obj_pend    (obj_pend)
);

// File: tb/tb_can_irq_id.sv
module tb_can_irq_id;
  localparam int NOBJ   = 14;
  localparam int CW     = $clog2(NOBJ + 3);
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic glb_en, stat_en, err_en;
  logic tx_ok_evt, rx_ok_evt, lec_evt, ewarn_chg, boff_chg;
  logic status_rd, txok_clr, rxok_clr;
  logic [NOBJ-1:0] obj_tx_done, obj_rx_done, obj_tx_en, obj_rx_en, obj_clr;
  logic spec_rx_done, spec_rx_en, spec_clr;
  logic [CW-1:0] irq_code;
  logic irq_req, stat_pend, spec_pend, tx_ok_flag, rx_ok_flag;
  logic [NOBJ-1:0] obj_pend;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Reference state
  bit m_stat, m_spec, m_txok, m_rxok;
  bit [NOBJ-1:0] m_obj;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_irq_id #(.NUM_OBJ(NOBJ)) dut (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .stat_en(stat_en), .err_en(err_en),
    .tx_ok_evt(tx_ok_evt), .rx_ok_evt(rx_ok_evt), .lec_evt(lec_evt),
    .ewarn_chg(ewarn_chg), .boff_chg(boff_chg), .status_rd(status_rd),
    .txok_clr(txok_clr), .rxok_clr(rxok_clr), .obj_tx_done(obj_tx_done),
    .obj_rx_done(obj_rx_done), .obj_tx_en(obj_tx_en), .obj_rx_en(obj_rx_en),
    .obj_clr(obj_clr), .spec_rx_done(spec_rx_done), .spec_rx_en(spec_rx_en),
    .spec_clr(spec_clr), .irq_code(irq_code), .irq_req(irq_req),
    .stat_pend(stat_pend), .spec_pend(spec_pend), .obj_pend(obj_pend),
    .tx_ok_flag(tx_ok_flag), .rx_ok_flag(rx_ok_flag)
  );

  function automatic int exp_code();
    if (m_stat) return 1;
    if (m_spec) return 2;
    for (int k = 0; k < NOBJ; k++) if (m_obj[k]) return k + 3;
    return 0;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle_pulses();
    tx_ok_evt = 0; rx_ok_evt = 0; lec_evt = 0; ewarn_chg = 0; boff_chg = 0;
    status_rd = 0; txok_clr = 0; rxok_clr = 0; obj_tx_done = '0; obj_rx_done = '0;
    obj_clr = '0; spec_rx_done = 0; spec_clr = 0;
  endtask

  task automatic upd_model();
    bit s_set;
    bit [NOBJ-1:0] o_set;
    s_set = (stat_en && (tx_ok_evt || rx_ok_evt || lec_evt)) || (err_en && (ewarn_chg || boff_chg));
    o_set = (obj_tx_done & obj_tx_en) | (obj_rx_done & obj_rx_en);
    m_stat = s_set || (m_stat && !status_rd);
    m_spec = (spec_rx_en && spec_rx_done) || (m_spec && !spec_clr);
    m_txok = tx_ok_evt || (m_txok && !txok_clr);
    m_rxok = rx_ok_evt || (m_rxok && !rxok_clr);
    m_obj  = o_set | (m_obj & ~obj_clr);
  endtask

  task automatic compare_all();
    int ec;
    ec = exp_code();
    chk(int'(irq_code) == ec, "R3 code", int'(irq_code), ec);
    chk(irq_req == (glb_en && ec != 0), "R4 request", int'(irq_req), int'(glb_en && ec != 0));
    chk(obj_pend == m_obj, "R7 object pending", int'(obj_pend), int'(m_obj));
    chk({stat_pend, spec_pend} == {m_stat, m_spec}, "R5 status/special pending",
        int'({stat_pend, spec_pend}), int'({m_stat, m_spec}));
    chk({tx_ok_flag, rx_ok_flag} == {m_txok, m_rxok}, "R9 ok flags",
        int'({tx_ok_flag, rx_ok_flag}), int'({m_txok, m_rxok}));
  endtask

  // One clock: inputs already set are captured, the model follows, outputs are compared.
  task automatic tick();
    @(posedge clk);
    upd_model();
    #2;
    compare_all();
    idle_pulses();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    int unsigned seed_sink;
    seed_sink = $urandom(32'd2024);
    rst_n = 0;
    glb_en = 1; stat_en = 1; err_en = 1; spec_rx_en = 1;
    obj_tx_en = '1; obj_rx_en = '1;
    idle_pulses();
    m_stat = 0; m_spec = 0; m_txok = 0; m_rxok = 0; m_obj = '0;
    repeat (3) @(posedge clk);
    #3 rst_n = 1;
    #1;
    // R1: reset state
    chk(irq_code == '0, "R1 code after reset", int'(irq_code), 0);
    chk(!irq_req, "R1 request after reset", int'(irq_req), 0);
    chk(obj_pend == '0 && !stat_pend && !spec_pend && !tx_ok_flag && !rx_ok_flag,
        "R1 pending after reset", int'(obj_pend), 0);

    // R2: last object maps to code 16
    obj_tx_done[13] = 1; tick();
    chk(irq_code == CW'(16), "R2 object 14 code", int'(irq_code), 16);
    obj_clr[13] = 1; tick();
    chk(irq_code == '0, "R2 empty code", int'(irq_code), 0);

    // R8: one transfer raises status and object 3 together
    tx_ok_evt = 1; obj_tx_done[2] = 1; tick();
    chk(irq_code == CW'(1), "R3 status outranks object", int'(irq_code), 1);
    status_rd = 1; tick();
    chk(irq_code == CW'(5), "R8 object code after status read", int'(irq_code), 5);
    chk(tx_ok_flag, "R9 tx ok survives status read", int'(tx_ok_flag), 1);
    txok_clr = 1; tick();
    chk(!tx_ok_flag, "R9 tx ok cleared", int'(tx_ok_flag), 0);
    obj_clr[2] = 1; tick();

    // R10: set and clear together
    obj_rx_done[0] = 1; obj_clr[0] = 1; tick();
    chk(obj_pend[0], "R10 object set wins", int'(obj_pend[0]), 1);
    obj_clr[0] = 1; tick();

    // R11: special object outranks ordinary objects
    obj_tx_done[5] = 1; spec_rx_done = 1; tick();
    chk(irq_code == CW'(2), "R11 special code", int'(irq_code), 2);
    spec_clr = 1; tick();
    chk(irq_code == CW'(8), "R11 special cleared", int'(irq_code), 8);
    obj_clr[5] = 1; tick();

    // R5: status events ignored while disabled; R9 flag still set
    stat_en = 0; rx_ok_evt = 1; lec_evt = 1; tick();
    chk(irq_code == '0, "R5 disabled status ignored", int'(irq_code), 0);
    chk(rx_ok_flag, "R9 rx ok flag set", int'(rx_ok_flag), 1);
    rxok_clr = 1; tick();

    // R6: error flag change
    boff_chg = 1; tick();
    chk(stat_pend && irq_code == CW'(1), "R6 error change sets code 1", int'(irq_code), 1);
    status_rd = 1; tick();
    chk(!stat_pend, "R9 status read clears", int'(stat_pend), 0);
    err_en = 0; ewarn_chg = 1; tick();
    chk(!stat_pend, "R6 disabled error ignored", int'(stat_pend), 0);

    // R7: disabled direction ignored
    obj_rx_en[4] = 0; obj_rx_done[4] = 1; tick();
    chk(!obj_pend[4], "R7 disabled receive ignored", int'(obj_pend[4]), 0);
    obj_tx_done[4] = 1; tick();
    chk(obj_pend[4], "R7 enabled transmit sets", int'(obj_pend[4]), 1);

    // R4: global enable gates only the request
    glb_en = 0; tick();
    chk(!irq_req && irq_code == CW'(7), "R4 gated request", int'(irq_req), 0);
    glb_en = 1; tick();
    chk(irq_req, "R4 request restored", int'(irq_req), 1);

    // Random phase
    for (int n = 0; n < 600; n++) begin
      if (($urandom % 16) == 0) begin
        glb_en = $urandom; stat_en = $urandom; err_en = $urandom; spec_rx_en = $urandom;
        obj_tx_en = NOBJ'($urandom); obj_rx_en = NOBJ'($urandom);
      end
      tx_ok_evt = ($urandom % 8) == 0;
      rx_ok_evt = ($urandom % 8) == 0;
      lec_evt   = ($urandom % 12) == 0;
      ewarn_chg = ($urandom % 16) == 0;
      boff_chg  = ($urandom % 16) == 0;
      status_rd = ($urandom % 4) == 0;
      txok_clr  = ($urandom % 5) == 0;
      rxok_clr  = ($urandom % 5) == 0;
      obj_tx_done  = NOBJ'($urandom) & NOBJ'($urandom) & NOBJ'($urandom);
      obj_rx_done  = NOBJ'($urandom) & NOBJ'($urandom) & NOBJ'($urandom);
      obj_clr      = NOBJ'($urandom) & NOBJ'($urandom);
      spec_rx_done = ($urandom % 6) == 0;
      spec_clr     = ($urandom % 4) == 0;
      tick();
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule